// File: doc/BRIEF.md
# Bus Port Duration Event Generator

This block watches one or more bus master ports and turns each clock of each port into a duration event. A separate counter bank can then count these events. For every port it reads four signals: the port's request, the acknowledge it gets from the bus, and two data-beat indicators, one for write data and one for read data. From these it registers four level outputs per port. The outputs mark write-data clocks, read-data clocks, idle clocks and acquisition-wait clocks. A counter that adds one per clock while an output is high therefore measures time spent in that condition, not the number of transactions.

Each port has a small sticky tracker. It remembers a request that has been raised but not yet acknowledged, so the wait is still timed if the master drops its request line early. The block does not arbitrate, move data or count. The number of ports is a parameter, and every output is a vector with one bit per port.

Top module: `dur_event_gen`

## Requirements
- R1: If a port's write-beat input is high on a clock edge, the port's write-duration output is high in the following cycle.
- R2: If a port's read-beat input is high and its write-beat input is low on an edge, the port's read-duration output is high in the following cycle. When both beats are high, only the write-duration output is raised.
- R3: If a port has no request, no pending request and no data beat on an edge, the port's idle output is high in the following cycle. The acknowledge input has no effect on this.
- R4: If a port has a request or a pending request, with no acknowledge and no data beat, on an edge, the port's latency output is high in the following cycle.
- R5: The cycle after an edge with the acknowledge high never shows latency. The acknowledge also clears the pending request.
- R6: A request sampled without an acknowledge stays pending after the request line falls. Latency continues until an acknowledge is sampled.
- R7: A data beat sampled while a request is outstanding produces a data output in the following cycle, not a latency output.
- R8: For each port, at most one of the four outputs is high in any cycle.
- R9: Outputs are registered one cycle after the sampled inputs. They are low while rst_ni is low, and reset clears any pending request.
- R10: Each port is classified only from its own inputs. The port count is set by the parameter NPORT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NPORT | Per-port transfer request |
| ack_i | input | NPORT | Per-port bus acknowledge (grant) |
| wr_beat_i | input | NPORT | Per-port write-data beat in progress |
| rd_beat_i | input | NPORT | Per-port read-data beat in progress |
| wr_dur_o | output | NPORT | Clock spent transferring write data |
| rd_dur_o | output | NPORT | Clock spent transferring read data |
| idle_o | output | NPORT | Clock with no request and no data |
| lat_dur_o | output | NPORT | Clock spent waiting for acquisition |

## Verification
The bench builds the block with NPORT set to 3. With three ports, one port can be put into acquisition wait while a second moves read data and the third stays idle. Every vector bit is compared on every checked cycle, so any crosstalk between replicated slices shows up. Three ports also give the generate loop a width where an indexing error at the middle or top slice becomes visible.

// File: rtl/dur_event_pkg.sv
package dur_event_pkg;

  typedef struct packed {
    logic wr;
    logic rd;
    logic idle;
    logic lat;
  } dur_ev_t;

  localparam dur_ev_t DUR_EV_NONE = '{wr: 1'b0, rd: 1'b0, idle: 1'b0, lat: 1'b0};

endpackage

// File: rtl/dur_pend_trk.sv
module dur_pend_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  // request without acknowledge arms, acknowledge clears
  always_comb begin
    pend_d = pend_q;
    if (ack_i)      pend_d = 1'b0;
    else if (req_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  p_pend_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_i) |=> pend_q);

  p_pend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> pend_q);

  p_pend_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !pend_q);

endmodule

// File: rtl/dur_port_cls.sv
module dur_port_cls
  import dur_event_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ack_i,
  input  logic    wr_beat_i,
  input  logic    rd_beat_i,
  input  logic    pend_i,
  output dur_ev_t ev_o
);

  dur_ev_t ev_d;
  dur_ev_t ev_q;
  logic    outstanding;
  logic    beat;

  assign outstanding = req_i | pend_i;
  assign beat        = wr_beat_i | rd_beat_i;

  // data beats win over waiting; write wins over read
  always_comb begin
    ev_d = DUR_EV_NONE;
    if (wr_beat_i)                 ev_d.wr   = 1'b1;
    else if (rd_beat_i)            ev_d.rd   = 1'b1;
    else if (!outstanding)         ev_d.idle = 1'b1;
    else if (!ack_i)               ev_d.lat  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= DUR_EV_NONE;
    else         ev_q <= ev_d;
  end

  assign ev_o = ev_q;

  p_wr_beat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_beat_i |=> (ev_q.wr && !ev_q.rd));

  p_rd_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_beat_i && !wr_beat_i) |=> ev_q.rd);

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !pend_i && !beat) |=> ev_q.idle);

  p_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outstanding && !ack_i && !beat) |=> ev_q.lat);

  p_no_lat_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ev_q.lat);

  p_beat_not_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outstanding && beat) |=> !ev_q.lat);

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_q));

  p_rst_low_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (ev_q == DUR_EV_NONE));

endmodule

// File: rtl/dur_event_gen.sv
module dur_event_gen
  import dur_event_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] req_i,
  input  logic [NPORT-1:0] ack_i,
  input  logic [NPORT-1:0] wr_beat_i,
  input  logic [NPORT-1:0] rd_beat_i,
  output logic [NPORT-1:0] wr_dur_o,
  output logic [NPORT-1:0] rd_dur_o,
  output logic [NPORT-1:0] idle_o,
  output logic [NPORT-1:0] lat_dur_o
);

  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic    [NPORT-1:0] pend;
  dur_ev_t [NPORT-1:0] ev;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [PW-1:0] PIDX = PW'(p);

    dur_pend_trk u_pend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i[PIDX]),
      .ack_i  (ack_i[PIDX]),
      .pend_o (pend[p])
    );

    dur_port_cls u_cls (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[PIDX]),
      .ack_i     (ack_i[PIDX]),
      .wr_beat_i (wr_beat_i[PIDX]),
      .rd_beat_i (rd_beat_i[PIDX]),
      .pend_i    (pend[p]),
      .ev_o      (ev[p])
    );

    assign wr_dur_o[p]  = ev[p].wr;
    assign rd_dur_o[p]  = ev[p].rd;
    assign idle_o[p]    = ev[p].idle;
    assign lat_dur_o[p] = ev[p].lat;
  end

endmodule

// File: tb/dur_event_gen_bench.sv
module dur_event_gen_bench;

  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req = '0, ack = '0, wrb = '0, rdb = '0;
  logic [NP-1:0] wr_o, rd_o, idle_o, lat_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dur_event_gen #(.NPORT(NP)) u_dur_event_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack),
    .wr_beat_i(wrb), .rd_beat_i(rdb),
    .wr_dur_o(wr_o), .rd_dur_o(rd_o), .idle_o(idle_o), .lat_dur_o(lat_o)
  );

  // code per port: {wr, rd, idle, lat}
  localparam logic [3:0] E_WR = 4'b1000, E_RD = 4'b0100, E_ID = 4'b0010,
                         E_LT = 4'b0001, E_NO = 4'b0000;

  task automatic drive(int p, logic r, logic a, logic w, logic d);
    req[p] = r; ack[p] = a; wrb[p] = w; rdb[p] = d;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [3:0] e0, logic [3:0] e1, logic [3:0] e2);
    logic [3:0] exp_v [NP];
    exp_v[0] = e0; exp_v[1] = e1; exp_v[2] = e2;
    for (int p = 0; p < NP; p++) begin
      logic [3:0] act;
      act = {wr_o[p], rd_o[p], idle_o[p], lat_o[p]};
      total++;
      if (act !== exp_v[p]) begin
        bad++;
        $display("FAIL %s port%0d act=%b exp=%b", tag, p, act, exp_v[p]);
      end
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    drive(0, 1, 0, 1, 0); drive(1, 1, 0, 0, 0); drive(2, 0, 0, 0, 1);
    tick(); chk("R9 in reset", E_NO, E_NO, E_NO);
    drive(0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0); drive(2, 0, 0, 0, 0);
    rst_n = 1'b1;
    tick(); chk("R3 idle after reset", E_ID, E_ID, E_ID);
  endtask

  task automatic t_data();
    drive(1, 0, 0, 1, 0); tick(); chk("R1 write beat", E_ID, E_WR, E_ID);
    drive(1, 0, 0, 0, 1); tick(); chk("R2 read beat", E_ID, E_RD, E_ID);
    drive(1, 0, 0, 1, 1); tick(); chk("R2 write priority", E_ID, E_WR, E_ID);
    drive(1, 0, 1, 0, 0); tick(); chk("R3 ack alone idle", E_ID, E_ID, E_ID);
  endtask

  task automatic t_wait();
    drive(0, 1, 0, 0, 0); tick(); chk("R4 wait 1", E_LT, E_ID, E_ID);
    tick(); chk("R4 wait 2", E_LT, E_ID, E_ID);
    drive(0, 1, 1, 0, 0); tick(); chk("R5 ack not latency", E_NO, E_ID, E_ID);
    drive(0, 0, 0, 0, 0); tick(); chk("R5 cleared to idle", E_ID, E_ID, E_ID);
  endtask

  task automatic t_sticky();
    drive(2, 1, 0, 0, 0); tick(); chk("R6 arm", E_ID, E_ID, E_LT);
    drive(2, 0, 0, 0, 0); tick(); chk("R6 req dropped", E_ID, E_ID, E_LT);
    tick(); chk("R6 still pending", E_ID, E_ID, E_LT);
    drive(2, 0, 1, 0, 0); tick(); chk("R5 ack ends wait", E_ID, E_ID, E_NO);
    drive(2, 0, 0, 0, 0); tick(); chk("R5 pending cleared", E_ID, E_ID, E_ID);
  endtask

  task automatic t_beat_pending();
    drive(0, 1, 0, 0, 0); tick(); chk("R7 wait", E_LT, E_ID, E_ID);
    drive(0, 1, 0, 1, 0); tick(); chk("R7 write over wait", E_WR, E_ID, E_ID);
    drive(0, 0, 0, 0, 1); tick(); chk("R7 read with pending", E_RD, E_ID, E_ID);
    drive(0, 0, 1, 0, 0); tick(); chk("R7 ack", E_NO, E_ID, E_ID);
    drive(0, 0, 0, 0, 0); tick(); chk("R7 back idle", E_ID, E_ID, E_ID);
  endtask

  task automatic t_ports();
    drive(0, 1, 0, 0, 0); drive(1, 0, 0, 0, 0); drive(2, 0, 0, 0, 1);
    tick(); chk("R10 mixed", E_LT, E_ID, E_RD);
    drive(0, 1, 0, 0, 0); drive(1, 0, 0, 1, 0); drive(2, 1, 0, 0, 0);
    tick(); chk("R10 mixed 2", E_LT, E_WR, E_LT);
  endtask

  task automatic t_reset_mid();
    drive(0, 0, 0, 0, 0); drive(1, 0, 0, 0, 0); drive(2, 0, 0, 0, 0);
    rst_n = 1'b0; #1;
    chk("R9 async reset", E_NO, E_NO, E_NO);
    rst_n = 1'b1;
    tick(); chk("R9 pending cleared", E_ID, E_ID, E_ID);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_data();
    t_wait();
    t_sticky();
    t_beat_pending();
    t_ports();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule